// File: doc/BRIEF.md
# Double-Data-Rate ADC Word Aligner

This block turns one serial lane of a multi-channel ADC into parallel samples. Each cycle of the bit clock carries two data bits, one per edge. In this model the two bits arrive together on a 2-bit input, and the earlier bit is on the upper lane. A 12-bit sample therefore spans six bit-clock cycles, which is one frame. The block does not know where a word starts. It finds out during training: while the ADC sends the deskew word (six ones followed by six zeros), the aligner moves its word boundary one bit at a time until that word appears in the same position several frames in a row.

Once the boundary is fixed, the aligner holds lock. It emits one registered 12-bit sample per frame with a one-cycle valid strobe. A second training word, alternating ones and zeros, can then be checked against the locked boundary. Each word that differs from it increments a saturating counter. A restart pulse drops lock and begins a new search. A device with several lanes uses one instance per lane.

Top module: `adc_frame_aligner`

## Requirements
- R1: After synchronous reset, `sample_vld`, `locked`, `align_err` and `sync_err_cnt` are all 0.
- R2: Bits enter most significant bit first, `din[1]` before `din[0]`. Once locked, successive valid samples equal successive transmitted 12-bit words, in order.
- R3: Before lock, the word is compared against the deskew value 0xFC0 (bits 11..6 one, bits 5..0 zero). On a mismatch the boundary moves by one bit. The next two words are then ignored, and lock is declared after four consecutive matching compares. This works from every one of the twelve possible bit offsets.
- R4: `sample_vld` is high only while `locked` is high. It is high for one cycle per frame, so consecutive strobes are exactly six cycles apart.
- R5: After twelve boundary moves without reaching lock, `align_err` is set and the search continues. `align_err` is cleared when lock is reached or when `restart` is pulsed.
- R6: While locked with `sync_chk` high, each received word that differs from 0xAAA (alternating bits, MSB one) adds one to `sync_err_cnt`. Matching words leave the count unchanged.
- R7: `sync_err_cnt` saturates at 255 and stays there.
- R8: While `sync_chk` is low, received words have no effect on `sync_err_cnt`.
- R9: A `restart` pulse clears `locked`, `align_err` and `sync_err_cnt` on the next cycle and starts a new search.
- R10: Once locked, the aligner stays locked whatever the data content is, until `restart` or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; two data bits per cycle |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 2 | Serial data pair; bit 1 is the earlier bit |
| restart | input | 1 | Pulse: drop lock, clear error and counter, search again |
| sync_chk | input | 1 | Enables counting of mismatches against the alternating pattern |
| sample | output | 12 | Aligned parallel sample |
| sample_vld | output | 1 | One-cycle strobe per frame while locked |
| locked | output | 1 | Word boundary found and held |
| align_err | output | 1 | A full pass of slip positions ended without lock |
| sync_err_cnt | output | 8 | Saturating count of words that differ from the alternating pattern |

## Verification
The bench builds the block with its defaults: 12-bit words, which give a six-cycle frame, two ignored frames after each slip, four matches to lock, and an 8-bit counter. With these values, a search from each of the twelve stream offsets completes within a few hundred cycles, so all twelve offsets are exercised, including the odd ones that need the half-cycle slip. The 255 ceiling can be reached with a few hundred corrupted words. Random data words, excluding the two training values, check ordering after lock, and an all-zero stream drives the search through a full pass to raise the error flag.

// File: rtl/adc_align_pkg.sv
package adc_align_pkg;

  typedef enum logic {ST_HUNT, ST_LOCK} align_st_e;

  // Upper half ones, lower half zeros.
  function automatic logic [63:0] deskew_word(input int w);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < w; i++) r[i] = (i >= w / 2);
    return r;
  endfunction

  // Alternating bits, most significant bit set.
  function automatic logic [63:0] alt_word(input int w);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < w; i++) r[i] = (((w - 1 - i) % 2) == 0);
    return r;
  endfunction

endpackage

// File: rtl/adc_bit_shifter.sv
module adc_bit_shifter #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        din,
  input  logic              slip,
  output logic              word_stb,
  output logic [WORD_W-1:0] word
);
  localparam int FRAME_CYC = WORD_W / 2;
  localparam int PH_W      = (FRAME_CYC > 1) ? $clog2(FRAME_CYC) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(FRAME_CYC - 1);

  logic [WORD_W:0]   hist;
  logic [PH_W-1:0]   phase;
  logic              half;

  function automatic logic [PH_W-1:0] ph_step(input logic [PH_W-1:0] p, input int s);
    int n;
    n = int'(p) + s;
    if (n >= FRAME_CYC) n = n - FRAME_CYC;
    return PH_W'(n);
  endfunction

  // A slip with half=0 takes the word one bit older.
  // A slip with half=1 clears half and captures one cycle early: net one bit older again.
  always_ff @(posedge clk) begin
    if (rst) begin
      hist  <= '0;
      phase <= '0;
      half  <= 1'b0;
    end else begin
      hist <= {hist[WORD_W-2:0], din[1], din[0]};
      if (slip && !half) begin
        half  <= 1'b1;
        phase <= ph_step(phase, 1);
      end else if (slip && half) begin
        half  <= 1'b0;
        phase <= ph_step(phase, 2);
      end else begin
        phase <= ph_step(phase, 1);
      end
    end
  end

  assign word_stb = (phase == PH_LAST);
  assign word     = half ? hist[WORD_W:1] : hist[WORD_W-1:0];

endmodule

// File: rtl/adc_align_ctrl.sv
module adc_align_ctrl
  import adc_align_pkg::*;
#(
  parameter int WORD_W      = 12,
  parameter int WAIT_FRAMES = 2,
  parameter int LOCK_WORDS  = 4,
  parameter int SLIP_LIMIT  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              word_stb,
  input  logic [WORD_W-1:0] word,
  output logic              slip,
  output logic              locked,
  output logic              align_err
);
  localparam logic [63:0]       DESK_FULL = deskew_word(WORD_W);
  localparam logic [WORD_W-1:0] DESK      = DESK_FULL[WORD_W-1:0];
  localparam int WT_W = $clog2(WAIT_FRAMES + 1) > 0 ? $clog2(WAIT_FRAMES + 1) : 1;
  localparam int MT_W = $clog2(LOCK_WORDS + 1);
  localparam int SL_W = $clog2(SLIP_LIMIT + 1);

  align_st_e       st;
  logic [WT_W-1:0] wait_cnt;
  logic [MT_W-1:0] match_cnt;
  logic [SL_W-1:0] slip_cnt;
  logic            compare;
  logic            hit;

  assign compare = word_stb && (st == ST_HUNT) && (wait_cnt == '0) && !restart;
  assign hit     = (word == DESK);
  assign slip    = compare && !hit;
  assign locked  = (st == ST_LOCK);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      st        <= ST_HUNT;
      wait_cnt  <= '0;
      match_cnt <= '0;
      slip_cnt  <= '0;
      align_err <= 1'b0;
    end else if (word_stb && st == ST_HUNT) begin
      if (wait_cnt != '0) begin
        wait_cnt <= wait_cnt - 1'b1;
      end else if (hit) begin
        if (match_cnt == MT_W'(LOCK_WORDS - 1)) begin
          st        <= ST_LOCK;
          match_cnt <= '0;
          slip_cnt  <= '0;
          align_err <= 1'b0;
        end else begin
          match_cnt <= match_cnt + 1'b1;
        end
      end else begin
        match_cnt <= '0;
        wait_cnt  <= WT_W'(WAIT_FRAMES);
        if (slip_cnt == SL_W'(SLIP_LIMIT - 1)) begin
          slip_cnt  <= '0;
          align_err <= 1'b1;
        end else begin
          slip_cnt <= slip_cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/adc_sync_monitor.sv
module adc_sync_monitor
  import adc_align_pkg::*;
#(
  parameter int WORD_W = 12,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              word_stb,
  input  logic              locked,
  input  logic              sync_chk,
  input  logic [WORD_W-1:0] word,
  output logic [CNT_W-1:0]  err_cnt
);
  localparam logic [63:0]       ALT_FULL = alt_word(WORD_W);
  localparam logic [WORD_W-1:0] ALT      = ALT_FULL[WORD_W-1:0];

  logic bump;
  assign bump = word_stb && locked && sync_chk && (word != ALT) && (err_cnt != '1);

  always_ff @(posedge clk) begin
    if (rst || restart) err_cnt <= '0;
    else if (bump)      err_cnt <= err_cnt + 1'b1;
  end

endmodule

// File: rtl/adc_frame_aligner.sv
module adc_frame_aligner #(
  parameter int WORD_W      = 12,
  parameter int WAIT_FRAMES = 2,
  parameter int LOCK_WORDS  = 4,
  parameter int CNT_W       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        din,
  input  logic              restart,
  input  logic              sync_chk,
  output logic [WORD_W-1:0] sample,
  output logic              sample_vld,
  output logic              locked,
  output logic              align_err,
  output logic [CNT_W-1:0]  sync_err_cnt
);
  logic              word_stb;
  logic [WORD_W-1:0] word;
  logic              slip;

  adc_bit_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .din(din), .slip(slip),
    .word_stb(word_stb), .word(word)
  );

  adc_align_ctrl #(
    .WORD_W(WORD_W), .WAIT_FRAMES(WAIT_FRAMES),
    .LOCK_WORDS(LOCK_WORDS), .SLIP_LIMIT(WORD_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .restart(restart), .word_stb(word_stb), .word(word),
    .slip(slip), .locked(locked), .align_err(align_err)
  );

  adc_sync_monitor #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_sync (
    .clk(clk), .rst(rst), .restart(restart), .word_stb(word_stb),
    .locked(locked), .sync_chk(sync_chk), .word(word), .err_cnt(sync_err_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sample     <= '0;
      sample_vld <= 1'b0;
    end else begin
      sample_vld <= word_stb && locked && !restart;
      if (word_stb && locked) sample <= word;
    end
  end

endmodule

// File: rtl/adc_frame_aligner_chk.sv
module adc_frame_aligner_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             restart,
  input logic             sync_chk,
  input logic             sample_vld,
  input logic             locked,
  input logic             align_err,
  input logic [CNT_W-1:0] sync_err_cnt
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  p_vld_locked_r4: assert property (@(posedge clk) disable iff (rst)
    sample_vld |-> locked);

  p_vld_single_r4: assert property (@(posedge clk) disable iff (rst)
    sample_vld |=> !sample_vld);

  p_lock_clear_err_r5: assert property (@(posedge clk) disable iff (rst)
    locked |-> !align_err);

  p_cnt_step_r6: assert property (@(posedge clk) disable iff (rst)
    !restart |=> (sync_err_cnt == $past(sync_err_cnt)) ||
                 (sync_err_cnt == CNT_W'($past(sync_err_cnt) + 1'b1)));

  p_cnt_sat_r7: assert property (@(posedge clk) disable iff (rst)
    (sync_err_cnt == CMAX && !restart) |=> sync_err_cnt == CMAX);

  p_cnt_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (!sync_chk && !restart) |=> $stable(sync_err_cnt));

  p_restart_clear_r9: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!locked && !align_err && sync_err_cnt == '0));

  p_lock_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (locked && !restart) |=> locked);

endmodule

bind adc_frame_aligner adc_frame_aligner_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .restart(restart), .sync_chk(sync_chk),
  .sample_vld(sample_vld), .locked(locked), .align_err(align_err),
  .sync_err_cnt(sync_err_cnt)
);

// File: tb/adc_frame_aligner_bench.sv
module adc_frame_aligner_bench;
  localparam int W = 12;
  localparam int NDATA = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   din = 2'b00;
  logic         restart = 1'b0;
  logic         sync_chk = 1'b0;
  logic [W-1:0] sample;
  logic         sample_vld;
  logic         locked;
  logic         align_err;
  logic [7:0]   sync_err_cnt;

  int checks = 0;
  int errors = 0;
  bit q[$];
  logic [W-1:0] obs[$];
  logic [W-1:0] sent[NDATA];
  bit   collect = 1'b0;
  int   cyc = 0;
  int   last_v = -1;
  int   gap_bad = 0;
  int   unlocked_vld = 0;

  always #4 clk = ~clk;

  adc_frame_aligner u_adc_frame_aligner (
    .clk(clk), .rst(rst), .din(din), .restart(restart), .sync_chk(sync_chk),
    .sample(sample), .sample_vld(sample_vld), .locked(locked),
    .align_err(align_err), .sync_err_cnt(sync_err_cnt)
  );

  function automatic logic [W-1:0] desk_val();
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = (i >= W / 2);
    return r;
  endfunction

  function automatic logic [W-1:0] alt_val();
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = (((W - 1 - i) % 2) == 0);
    return r;
  endfunction

  function automatic int sat_add(input int a, input int b);
    return (a + b > 255) ? 255 : a + b;
  endfunction

  task automatic push_word(input logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) q.push_back(w[i]);
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  // Stream driver: idle fill is the alternating word, kept word-aligned.
  always @(negedge clk) begin
    bit b1, b0;
    if (q.size() < 2) push_word(alt_val());
    b1 = q.pop_front();
    b0 = q.pop_front();
    din <= {b1, b0};
  end

  // Output monitor, sampled away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (!rst && sample_vld) begin
      if (!locked) unlocked_vld++;
      if (last_v >= 0 && cyc - last_v != W / 2) gap_bad++;
      last_v = cyc;
      if (collect) obs.push_back(sample);
    end
  end

  task automatic do_restart();
    @(negedge clk) restart = 1'b1;
    @(negedge clk) restart = 1'b0;
    last_v = -1;
  endtask

  task automatic drain();
    while (q.size() > W) @(negedge clk);
    repeat (30) @(negedge clk);
  endtask

  task automatic run_align(input int off);
    int k;
    logic [W-1:0] w;
    do_restart();
    obs.delete();
    collect = 1'b1;
    for (int i = 0; i < off; i++) q.push_back(1'($urandom));
    for (int i = 0; i < 64; i++) push_word(desk_val());
    for (int i = 0; i < NDATA; i++) begin
      do w = W'($urandom); while (w == desk_val() || w == alt_val());
      sent[i] = w;
      push_word(w);
    end
    drain();
    collect = 1'b0;
    chk($sformatf("R3 lock offset %0d", off), {31'd0, locked}, 32'd1);
    chk("R5 error clear on lock", {31'd0, align_err}, 32'd0);
    k = 0;
    while (k < obs.size() && obs[k] == desk_val()) k++;
    for (int i = 0; i < NDATA; i++) begin
      if (k + i < obs.size()) chk($sformatf("R2 word %0d", i), {20'd0, obs[k+i]}, {20'd0, sent[i]});
      else chk($sformatf("R2 word %0d missing", i), 32'hFFFF, {20'd0, sent[i]});
    end
    chk("R10 lock held over data", {31'd0, locked}, 32'd1);
  endtask

  initial begin
    int exp_cnt;
    logic [W-1:0] bad;
    void'($urandom(32'd20240917));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 vld", {31'd0, sample_vld}, 32'd0);
    chk("R1 locked", {31'd0, locked}, 32'd0);
    chk("R1 err", {31'd0, align_err}, 32'd0);
    chk("R1 count", {24'd0, sync_err_cnt}, 32'd0);

    for (int off = 0; off < W; off++) run_align(off);

    // R5: a stream with no deskew word exhausts the slips.
    do_restart();
    for (int i = 0; i < 60; i++) push_word('0);
    drain();
    chk("R5 error raised", {31'd0, align_err}, 32'd1);
    chk("R5 not locked", {31'd0, locked}, 32'd0);
    do_restart();
    @(negedge clk);
    chk("R5 error cleared by restart", {31'd0, align_err}, 32'd0);
    run_align(int'($urandom_range(0, W - 1)));

    // R6: mismatch counting against the alternating word.
    exp_cnt = 0;
    sync_chk = 1'b1;
    for (int i = 0; i < 15; i++) begin
      if (i % 3 == 1) begin
        do bad = alt_val() ^ W'($urandom); while (bad == alt_val());
        push_word(bad);
        exp_cnt = sat_add(exp_cnt, 1);
      end else push_word(alt_val());
    end
    drain();
    chk("R6 mismatch count", {24'd0, sync_err_cnt}, exp_cnt);

    // R8: counting disabled.
    sync_chk = 1'b0;
    for (int i = 0; i < 7; i++) push_word(~alt_val());
    drain();
    chk("R8 count unchanged", {24'd0, sync_err_cnt}, exp_cnt);

    // R7: saturation.
    sync_chk = 1'b1;
    for (int i = 0; i < 300; i++) begin
      do bad = W'($urandom); while (bad == alt_val());
      push_word(bad);
      exp_cnt = sat_add(exp_cnt, 1);
    end
    drain();
    chk("R7 saturated", {24'd0, sync_err_cnt}, exp_cnt);
    sync_chk = 1'b0;

    // R9: restart clears everything.
    do_restart();
    chk("R9 locked", {31'd0, locked}, 32'd0);
    chk("R9 count", {24'd0, sync_err_cnt}, 32'd0);
    chk("R9 err", {31'd0, align_err}, 32'd0);

    chk("R4 strobe spacing", gap_bad, 32'd0);
    chk("R4 strobe only when locked", unlocked_vld, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired got running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule